// File: doc/BRIEF.md
# Shared-Adder Multicycle Arithmetic Unit

This block is an integer arithmetic unit in which a single ripple adder does every piece of arithmetic. Loading a value, adding and subtracting each take one pass through the adder. Multiplying and dividing take many passes. Each pass reuses the same adder alongside an accumulator and a rotating register. Subtraction is done by XOR-inverting the second adder input and forcing the carry-in high.

The accumulator has no load multiplexer. A value reaches it by going through the adder with the other adder input forced to zero. Multiplication is shift-and-add: the multiplier sits in the rotating register, and each step conditionally adds the multiplicand and then shifts the pair right. Division is restoring: each step shifts the partial remainder left, tries a subtraction, and uses the carry out to decide whether to keep the difference or the shifted value. The resulting quotient bit is shifted into the rotating register.

A caller presents two operands and an operation code, pulses `start`, and waits for the one-cycle `done` pulse. The width is the parameter `W`, which defaults to 16.

Top module: `shared_alu`

## Requirements
- R1: Op code 0 (load) places `opa` on `result` one cycle after start, with `aux` = 0 and `flag` = 0. A start is sampled at a rising edge, and "L cycles after start" means the value is visible after the L-th rising edge, counting the start edge as the first.
- R2: Op code 1 (add) gives `result` = (`opa` + `opb`) mod 2^W and `flag` = the carry out, one cycle after start.
- R3: Op code 2 (subtract) gives `result` = (`opa` − `opb`) mod 2^W and `flag` = 1 exactly when `opa` ≥ `opb` (inverted borrow), one cycle after start.
- R4: Op code 3 (multiply) gives {`aux`,`result`} = `opa` × `opb` (2W bits, `aux` high) and `flag` = 0, W+1 cycles after start: one load cycle followed by W iterations.
- R5: Op code 4 (divide) with a nonzero `opb` gives `result` = `opa` / `opb` and `aux` = `opa` mod `opb`, with `flag` = 0, W+1 cycles after start.
- R6: A divide with `opb` = 0 raises `err` and pulses `done` one cycle after start, and leaves `result`, `aux` and `flag` unchanged. The next accepted start clears `err`.
- R7: A start that arrives while a multiply or divide is running is ignored, as is a start carrying op codes 5 to 7. Neither produces a `done` pulse or changes the outputs.
- R8: Every accepted operation produces exactly one `done` pulse, one cycle long, in the cycle its results become valid.
- R9: A synchronous active-high `rst` clears `result`, `aux`, `flag`, `err`, `done` and the controller state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation |
| op | input | 3 | Operation code (0 load, 1 add, 2 subtract, 3 multiply, 4 divide) |
| opa | input | W | First operand, dividend or multiplier |
| opb | input | W | Second operand, divisor or multiplicand |
| result | output | W | Main result, product low half or quotient |
| aux | output | W | Product high half or remainder, otherwise zero |
| flag | output | 1 | Carry or inverted borrow |
| err | output | 1 | Divide by zero |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds one copy with W = 4. At that width every operand pair can be swept through add, subtract, multiply and divide, so every carry, borrow, restore and overflow-into-the-top-bit path of the shared adder is reached and checked against arithmetic computed in the bench. A second copy uses the default W = 16 and runs pseudo-random and extreme operands, which confirms that the iteration count and the double-width result layout scale with the parameter. Directed sequences cover the busy-time start, the unused op codes and the zero divisor.

// File: rtl/shared_alu.sv
module shared_alu #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] result,
  output logic [W-1:0] aux,
  output logic         flag,
  output logic         err,
  output logic         done
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [2:0] OP_LOAD = 3'd0, OP_ADD = 3'd1, OP_SUB = 3'd2,
                         OP_MUL = 3'd3, OP_DIV = 3'd4;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  typedef enum logic [1:0] {S_IDLE, S_MUL, S_DIV} state_t;

  state_t        st;
  logic [W-1:0]  acc, rot, breg;
  logic [CW-1:0] cnt;
  logic          wide, flag_q, err_q, done_q;

  logic [W-1:0]  add_a, add_b, b_eff, shl, sum;
  logic          inv, cout, take;
  logic [W:0]    full;

  wire accept = start && (st == S_IDLE) && (op <= OP_DIV);
  wire busy   = (st != S_IDLE);

  assign shl = {acc[W-2:0], rot[W-1]};

  always_comb begin
    add_a = '0;
    add_b = '0;
    inv   = 1'b0;
    case (st)
      S_IDLE: begin
        if (op == OP_LOAD || op == OP_ADD || op == OP_SUB) add_a = opa;
        if (op == OP_ADD || op == OP_SUB) add_b = opb;
        if (op == OP_SUB) inv = 1'b1;
      end
      S_MUL: begin
        add_a = acc;
        add_b = rot[0] ? breg : '0;
      end
      S_DIV: begin
        add_a = shl;
        add_b = breg;
        inv   = 1'b1;
      end
      default: ;
    endcase
  end

  assign b_eff       = add_b ^ {W{inv}};
  assign full        = {1'b0, add_a} + {1'b0, b_eff} + {{W{1'b0}}, inv};
  assign {cout, sum} = full;
  assign take        = acc[W-1] | cout;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      acc    <= '0;
      rot    <= '0;
      breg   <= '0;
      cnt    <= '0;
      wide   <= 1'b0;
      flag_q <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          if (op == OP_DIV && opb == '0) begin
            err_q  <= 1'b1;
            done_q <= 1'b1;
          end else begin
            acc    <= sum;
            flag_q <= cout;
            err_q  <= 1'b0;
            if (op == OP_MUL || op == OP_DIV) begin
              rot  <= opa;
              breg <= opb;
              cnt  <= '0;
              wide <= 1'b1;
              st   <= (op == OP_MUL) ? S_MUL : S_DIV;
            end else begin
              wide   <= 1'b0;
              done_q <= 1'b1;
            end
          end
        end
        S_MUL: begin
          acc <= {cout, sum[W-1:1]};
          rot <= {sum[0], rot[W-1:1]};
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end
        end
        S_DIV: begin
          acc <= take ? sum : shl;
          rot <= {rot[W-2:0], take};
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign result = wide ? rot : acc;
  assign aux    = wide ? acc : '0;
  assign flag   = flag_q;
  assign err    = err_q;
  assign done   = done_q;

  logic [W-1:0] chk_a, chk_b;
  logic [2:0]   chk_op;
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_a  <= '0;
      chk_b  <= '0;
      chk_op <= '0;
    end else if (accept) begin
      chk_a  <= opa;
      chk_b  <= opb;
      chk_op <= op;
    end
  end

  assert_add_carry_R2: assert property (@(posedge clk) disable iff (rst)
    (accept && op == OP_ADD) |=> ({flag, result} == {1'b0, $past(opa)} + {1'b0, $past(opb)}));

  assert_sub_borrow_R3: assert property (@(posedge clk) disable iff (rst)
    (accept && op == OP_SUB) |=> (result == $past(opa) - $past(opb) && flag == ($past(opa) >= $past(opb))));

  assert_mul_product_R4: assert property (@(posedge clk) disable iff (rst)
    (done && chk_op == OP_MUL) |-> ({aux, result} == {{W{1'b0}}, chk_a} * {{W{1'b0}}, chk_b}));

  assert_div_quot_rem_R5: assert property (@(posedge clk) disable iff (rst)
    (done && chk_op == OP_DIV && chk_b != '0) |-> (result == chk_a / chk_b && aux == chk_a % chk_b));

  assert_div_zero_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (result == $past(result) && aux == $past(aux) && flag == $past(flag)));

  assert_busy_ignores_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != LAST) |=> (busy && !done));

  assert_done_source_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(accept) || $past(busy)));

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (result == '0 && aux == '0 && !flag && !err && !done));
endmodule

// File: tb/shared_alu_bench.sv
module shared_alu_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1;
  logic        start_s = 1'b0, start_w = 1'b0;
  logic [2:0]  op = '0;
  logic [15:0] opa = '0, opb = '0;

  logic [3:0]  res_s, aux_s;
  logic        flag_s, err_s, done_s;
  logic [15:0] res_w, aux_w;
  logic        flag_w, err_w, done_w;

  shared_alu #(.W(4)) u_shared_alu (
    .clk(clk), .rst(rst), .start(start_s), .op(op), .opa(opa[3:0]), .opb(opb[3:0]),
    .result(res_s), .aux(aux_s), .flag(flag_s), .err(err_s), .done(done_s));

  shared_alu #(.W(16)) u_shared_alu_w16 (
    .clk(clk), .rst(rst), .start(start_w), .op(op), .opa(opa), .opb(opb),
    .result(res_w), .aux(aux_w), .flag(flag_w), .err(err_w), .done(done_w));

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic run(input bit w, input logic [2:0] o, input logic [15:0] a, input logic [15:0] b,
                     output int lat);
    @(negedge clk);
    op = o; opa = a; opb = b;
    if (w) start_w = 1'b1; else start_s = 1'b1;
    @(negedge clk);
    start_s = 1'b0; start_w = 1'b0;
    lat = 1;
    while (!(w ? done_w : done_s) && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int lat;
    int dones;
    logic [31:0] seed;
    repeat (3) @(negedge clk);
    chk("R9 reset result", {res_s, aux_s, flag_s, err_s, done_s}, 0);
    chk("R9 reset wide", {res_w, flag_w, err_w, done_w}, 0);
    rst = 1'b0;

    run(0, 3'd0, 16'd9, 16'd5, lat);
    chk("R1 load latency", lat, 1);
    chk("R1 load value", {aux_s, res_s, flag_s}, {4'd0, 4'd9, 1'b0});

    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        run(0, 3'd1, 16'(a), 16'(b), lat);
        chk("R2 add latency", lat, 1);
        chk("R2 add", {flag_s, res_s}, 32'(a + b));
        run(0, 3'd2, 16'(a), 16'(b), lat);
        chk("R3 sub", {flag_s, res_s}, {a >= b, 4'((a - b) & 15)});
        run(0, 3'd3, 16'(a), 16'(b), lat);
        chk("R4 mul latency", lat, 5);
        chk("R4 mul", {flag_s, aux_s, res_s}, 32'(a * b));
        if (b != 0) begin
          run(0, 3'd4, 16'(a), 16'(b), lat);
          chk("R5 div latency", lat, 5);
          chk("R5 div", {flag_s, err_s, aux_s, res_s}, {2'b00, 4'(a % b), 4'(a / b)});
        end
      end
    end

    run(0, 3'd3, 16'd3, 16'd5, lat);
    run(0, 3'd4, 16'd7, 16'd0, lat);
    chk("R6 div zero latency", lat, 1);
    chk("R6 div zero hold", {err_s, flag_s, aux_s, res_s}, {1'b1, 1'b0, 4'd0, 4'd15});
    run(0, 3'd1, 16'd2, 16'd3, lat);
    chk("R6 err cleared", {err_s, res_s}, {1'b0, 4'd5});

    @(negedge clk);
    op = 3'd3; opa = 16'd13; opb = 16'd11; start_s = 1'b1;
    @(negedge clk); start_s = 1'b0;
    @(negedge clk);
    op = 3'd1; opa = 16'd1; opb = 16'd1; start_s = 1'b1;
    @(negedge clk); start_s = 1'b0;
    dones = 0;
    for (int i = 0; i < 10; i++) begin
      if (done_s) dones++;
      @(negedge clk);
    end
    chk("R7 busy start ignored", {aux_s, res_s}, 32'(13 * 11));
    chk("R8 single done pulse", dones, 1);

    run(0, 3'd0, 16'd9, 16'd0, lat);
    @(negedge clk);
    op = 3'd5; opa = 16'd2; opb = 16'd2; start_s = 1'b1;
    @(negedge clk); start_s = 1'b0;
    dones = 0;
    for (int i = 0; i < 4; i++) begin
      if (done_s) dones++;
      @(negedge clk);
    end
    chk("R7 unused op no done", dones, 0);
    chk("R7 unused op no change", {aux_s, res_s}, 32'd9);

    run(1, 3'd3, 16'hFFFF, 16'hFFFF, lat);
    chk("R4 wide mul latency", lat, 17);
    chk("R4 wide mul max", {aux_w, res_w}, 32'hFFFE0001);
    run(1, 3'd4, 16'hFFFF, 16'd1, lat);
    chk("R5 wide div by one", {aux_w, res_w}, 32'h0000FFFF);
    run(1, 3'd4, 16'h1234, 16'hFFFF, lat);
    chk("R5 wide div small", {aux_w, res_w}, 32'h12340000);
    run(1, 3'd1, 16'hFFFF, 16'd1, lat);
    chk("R2 wide carry", {flag_w, res_w}, 32'h10000);
    run(1, 3'd2, 16'd1, 16'd2, lat);
    chk("R3 wide borrow", {flag_w, res_w}, 32'h0FFFF);
    seed = 32'h1ACE_B00C;
    for (int i = 0; i < 40; i++) begin
      logic [15:0] x, y;
      seed = seed * 32'd1103515245 + 32'd12345;
      x = seed[31:16];
      seed = seed * 32'd1103515245 + 32'd12345;
      y = seed[31:16] | 16'd1;
      run(1, 3'd3, x, y, lat);
      chk("R4 wide mul", {aux_w, res_w}, {16'd0, x} * {16'd0, y});
      run(1, 3'd4, x, y, lat);
      chk("R5 wide div", {aux_w, res_w}, {x % y, x / y});
    end

    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R9 sync reset", {res_w, aux_w, flag_w, err_w, done_w}, 0);
    finish_run();
  end
endmodule